// File: doc/BRIEF.md
# Microcoded Shared-Bus Processor Core

This block is a small processor core in which every transfer between state elements passes over one internal bus. A control store indexed by the current microstate produces one control word per cycle. That word says which single source drives the bus, which registers capture the bus value, what the ALU does, whether memory is accessed, and which microstate comes next. The state elements are a program counter, an instruction register, two ALU operand latches, a register-index latch, a 32-entry register file and a memory address register.

The core fetches instructions by itself from a word-wide memory slave and then advances the program counter. It runs two operations: a three-register add, and an add whose first operand is read from memory at the address held in a register. Every other encoding is reported as illegal and skipped. Any microstate that reads memory holds the sequencer until the slave answers with a ready pulse.

Top module: `mcbus_core`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, `mem_req`, `illegal` and `bus_err` are low. After release, the first memory request is an instruction fetch at address 0.
- R2: Instructions are fetched from consecutive addresses 0, 4, 8, … Each instruction, legal or not, advances the fetch address by exactly 4.
- R3: An add is encoded with bits 31:26 = 0, funct bits 5:0 = 0x20 and bits 10:6 = 0. The source fields are bits 25:21 (first) and 20:16 (second), and the destination field is bits 15:11. It writes (first + second) mod 2^32 to the destination register. From one fetch request to the next it takes L+10 cycles, where L is the fetch's ready latency in cycles.
- R4: A memory add has the same encoding with funct 0x28. It issues one read at the address held in the first source register and writes (read word + second source register) mod 2^32 to the destination. Fetch to fetch takes L+L2+11 cycles, where L2 is the data read's ready latency.
- R5: While a read is pending without `mem_ready`, the microstate and `mem_addr` stay frozen, for any latency of 0 or more cycles.
- R6: Register 0 reads as zero, and writing it has no effect.
- R7: Any other encoding (a nonzero bits 31:26, a funct other than 0x20 or 0x28, or nonzero bits 10:6) raises `illegal` for exactly one cycle and changes no register. The next fetch follows L+4 cycles after the fetch request.
- R8: At most one source drives the internal bus in any cycle, and `bus_err` never rises.
- R9: Neither the fetch microstates nor the two operations issue a write request (`mem_we` stays low on every request).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request (word aligned for fetches) |
| mem_wdata | output | 32 | Write data (current bus value) |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | One-cycle completion pulse from the slave |
| illegal | output | 1 | One-cycle pulse for an unrecognized instruction |
| bus_err | output | 1 | Registered flag: more than one bus driver was enabled |

## Verification
The register file cannot be observed directly. An add's result becomes visible only when a later memory add uses that register as its address source, so that the value appears on `mem_addr`. The stimulus first loads every register through memory adds, then runs directed pairs of an add followed by a memory add addressed by its destination. After that comes a long random mix in which memory adds pick random address registers. Ready latencies vary between zero and several cycles on both fetches and data reads. The fetch-to-fetch cycle counts pin down the microstate sequences.

// File: rtl/mcbus_pkg.sv
package mcbus_pkg;

  typedef enum logic [4:0] {
    S_F0, S_F1, S_F2, S_F3,
    S_A0, S_A1, S_A2, S_A3, S_A4, S_A5,
    S_M0, S_M1, S_M2, S_M3, S_M4, S_M5, S_M6
  } ustate_t;

  typedef enum logic [1:0] {ALU_NOP, ALU_ADD, ALU_INC} aluop_t;
  typedef enum logic [1:0] {FS_RS, FS_RT, FS_RD} fsel_t;

  typedef struct packed {
    logic    le_pc;
    logic    en_pc;
    logic    le_ir;
    logic    en_ir;
    logic    le_a;
    logic    le_b;
    aluop_t  alu;
    logic    en_alu;
    fsel_t   fsel;
    logic    le_idx;
    logic    rf_we;
    logic    en_rf;
    logic    le_mar;
    logic    mem_rd;
    logic    mem_wr;
    logic    en_mem;
    logic    dispatch;
    ustate_t nxt;
  } uword_t;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] FN_ADD    = 6'h20;
  localparam logic [5:0] FN_ADDM   = 6'h28;
  localparam int RS_LSB = 21;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;
  localparam int FLD_W  = 5;

endpackage

// File: rtl/mcbus_ustore.sv
module mcbus_ustore
  import mcbus_pkg::*;
(
  input  ustate_t st,
  output uword_t  uw
);
  always_comb begin
    uw     = '0;
    uw.nxt = S_F0;
    case (st)
      S_F0: begin uw.en_pc = 1'b1; uw.le_mar = 1'b1; uw.le_a = 1'b1; uw.nxt = S_F1; end
      S_F1: begin uw.mem_rd = 1'b1; uw.en_mem = 1'b1; uw.le_ir = 1'b1; uw.nxt = S_F2; end
      S_F2: begin uw.alu = ALU_INC; uw.en_alu = 1'b1; uw.le_pc = 1'b1; uw.nxt = S_F3; end
      S_F3: begin uw.dispatch = 1'b1; end
      S_A0: begin uw.en_ir = 1'b1; uw.fsel = FS_RS; uw.le_idx = 1'b1; uw.nxt = S_A1; end
      S_A1: begin uw.en_rf = 1'b1; uw.le_a = 1'b1; uw.nxt = S_A2; end
      S_A2: begin uw.en_ir = 1'b1; uw.fsel = FS_RT; uw.le_idx = 1'b1; uw.nxt = S_A3; end
      S_A3: begin uw.en_rf = 1'b1; uw.le_b = 1'b1; uw.nxt = S_A4; end
      S_A4: begin uw.en_ir = 1'b1; uw.fsel = FS_RD; uw.le_idx = 1'b1; uw.nxt = S_A5; end
      S_A5: begin uw.alu = ALU_ADD; uw.en_alu = 1'b1; uw.rf_we = 1'b1; uw.nxt = S_F0; end
      S_M0: begin uw.en_ir = 1'b1; uw.fsel = FS_RS; uw.le_idx = 1'b1; uw.nxt = S_M1; end
      S_M1: begin uw.en_rf = 1'b1; uw.le_mar = 1'b1; uw.nxt = S_M2; end
      S_M2: begin uw.mem_rd = 1'b1; uw.en_mem = 1'b1; uw.le_a = 1'b1; uw.nxt = S_M3; end
      S_M3: begin uw.en_ir = 1'b1; uw.fsel = FS_RT; uw.le_idx = 1'b1; uw.nxt = S_M4; end
      S_M4: begin uw.en_rf = 1'b1; uw.le_b = 1'b1; uw.nxt = S_M5; end
      S_M5: begin uw.en_ir = 1'b1; uw.fsel = FS_RD; uw.le_idx = 1'b1; uw.nxt = S_M6; end
      S_M6: begin uw.alu = ALU_ADD; uw.en_alu = 1'b1; uw.rf_we = 1'b1; uw.nxt = S_F0; end
      default: uw.nxt = S_F0;
    endcase
  end
endmodule

// File: rtl/mcbus_alu.sv
module mcbus_alu
  import mcbus_pkg::*;
#(
  parameter int W = 32
) (
  input  aluop_t         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  localparam logic [W-1:0] STEP = W'(W / 8);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_INC: y = a + STEP;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mcbus_regfile.sv
module mcbus_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && idx != '0) mem[idx] <= wdata;
  end

  assign rdata = (idx == '0) ? '0 : mem[idx];
endmodule

// File: rtl/mcbus_core.sv
module mcbus_core
  import mcbus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              illegal,
  output logic              bus_err
);
  localparam int IDX_W = $clog2(NREG);
  localparam int NDRV  = 5;

  ustate_t           state, nxt;
  uword_t            uw;
  logic [DATA_W-1:0] pc, ir, a_q, b_q, mar, bus, alu_y, rf_q;
  logic [IDX_W-1:0]  idx;
  logic [FLD_W-1:0]  fld;
  logic [NDRV-1:0]   drv;
  logic              stall, adv, is_add, is_addm, illegal_d;

  mcbus_ustore u_rom (.st(state), .uw(uw));

  mcbus_alu #(.W(DATA_W)) u_alu (.op(uw.alu), .a(a_q), .b(b_q), .y(alu_y));

  mcbus_regfile #(.W(DATA_W), .DEPTH(NREG)) u_rf (
    .clk(clk), .we(adv & uw.rf_we), .idx(idx), .wdata(bus), .rdata(rf_q));

  always_comb begin
    case (uw.fsel)
      FS_RS:   fld = ir[RS_LSB +: FLD_W];
      FS_RT:   fld = ir[RT_LSB +: FLD_W];
      default: fld = ir[RD_LSB +: FLD_W];
    endcase
  end

  // drive vector: one bit per possible bus source
  assign drv = {uw.en_pc, uw.en_ir, uw.en_alu, uw.en_rf, uw.en_mem};

  always_comb begin
    bus = '0;
    if (uw.en_pc)  bus = bus | pc;
    if (uw.en_ir)  bus = bus | {{(DATA_W-FLD_W){1'b0}}, fld};
    if (uw.en_alu) bus = bus | alu_y;
    if (uw.en_rf)  bus = bus | rf_q;
    if (uw.en_mem) bus = bus | mem_rdata;
  end

  assign mem_req   = uw.mem_rd | uw.mem_wr;
  assign mem_we    = uw.mem_wr;
  assign mem_addr  = mar;
  assign mem_wdata = bus;

  assign stall = mem_req & ~mem_ready;
  assign adv   = ~stall;

  assign is_add  = (ir[31:26] == OPC_RTYPE) && (ir[5:0] == FN_ADD)  && (ir[10:6] == '0);
  assign is_addm = (ir[31:26] == OPC_RTYPE) && (ir[5:0] == FN_ADDM) && (ir[10:6] == '0);
  assign illegal_d = uw.dispatch & ~is_add & ~is_addm;

  always_comb begin
    if (stall)            nxt = state;
    else if (uw.dispatch) nxt = is_add ? S_A0 : (is_addm ? S_M0 : S_F0);
    else                  nxt = uw.nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_F0;
      pc      <= '0;
      ir      <= '0;
      a_q     <= '0;
      b_q     <= '0;
      mar     <= '0;
      idx     <= '0;
      illegal <= 1'b0;
      bus_err <= 1'b0;
    end else begin
      state   <= nxt;
      illegal <= illegal_d;
      bus_err <= ($countones(drv) > 1);
      if (adv) begin
        if (uw.le_pc)  pc  <= bus;
        if (uw.le_ir)  ir  <= bus;
        if (uw.le_a)   a_q <= bus;
        if (uw.le_b)   b_q <= bus;
        if (uw.le_mar) mar <= bus;
        if (uw.le_idx) idx <= bus[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mcbus_chk.sv
module mcbus_chk
  import mcbus_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 5,
  parameter int NDRV  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_req,
  input logic             mem_ready,
  input logic [W-1:0]     mem_addr,
  input ustate_t          st,
  input logic [W-1:0]     pc,
  input logic [NDRV-1:0]  drv,
  input logic             en_rf,
  input logic [IDX_W-1:0] idx,
  input logic [W-1:0]     bus,
  input logic             illegal,
  input logic             bus_err
);
  a_r8_single_driver: assert property (@(posedge clk) disable iff (rst) $onehot0(drv));

  a_r8_no_bus_err: assert property (@(posedge clk) disable iff (rst) !bus_err);

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> ($stable(st) && $stable(mem_addr)));

  a_r6_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (en_rf && idx == '0) |-> (bus == '0));

  a_r7_back_to_fetch: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (st == S_F0));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    illegal |=> !illegal);

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_F2) |=> (pc == $past(pc) + W'(4)));
endmodule

bind mcbus_core mcbus_chk u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .st(state), .pc(pc), .drv(drv), .en_rf(uw.en_rf),
  .idx(idx), .bus(bus), .illegal(illegal), .bus_err(bus_err));

// File: tb/sim_mcbus_core.sv
`timescale 1ns/1ps
module sim_mcbus_core;
  localparam logic [5:0] F_ADD  = 6'h20;
  localparam logic [5:0] F_ADDM = 6'h28;
  localparam int MAXP = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_req, mem_we, illegal, bus_err;
  logic [31:0] mem_addr, mem_wdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ill_seen = 0;
  bit done = 1'b0;

  logic [31:0] prog [MAXP];
  int          nprog = 0;
  logic [31:0] rf [32];

  mcbus_core u0 (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .illegal(illegal), .bus_err(bus_err));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!rst && illegal) ill_seen <= ill_seen + 1;

  function automatic logic [31:0] enc(input logic [5:0] op, input int rs, input int rt,
                                      input int rd, input logic [4:0] sh, input logic [5:0] fn);
    return {op, 5'(rs), 5'(rt), 5'(rd), sh, fn};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (a < 32'(4 * nprog)) return prog[a[9:2]];
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic serve(input logic [31:0] exp_addr, input string req, input int lat,
                       output int t_req);
    logic [31:0] a0;
    while (!mem_req) @(negedge clk);
    t_req = cyc;
    a0 = mem_addr;
    chk(mem_addr === exp_addr, req, "request address", mem_addr, exp_addr);
    chk(mem_we === 1'b0, "R9", "write flag on request", 32'(mem_we), 32'd0);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk(mem_req === 1'b1 && mem_addr === a0, "R5", "held request while stalled",
          mem_addr, a0);
    end
    mem_rdata = mem_word(mem_addr);
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
  endtask

  function automatic int pick_lat(input int i);
    if (i % 17 == 3) return 7;
    if (i % 11 == 5) return 0;
    return int'($urandom % 4);
  endfunction

  initial begin
    int exp_ill, exp_t, t0, t1, l1, l2, rs, rt, rd, kind;
    logic [31:0] w, v;
    bit have_t;
    void'($urandom(32'd4242));

    // program: load all registers, directed cases, random mix
    for (int r = 1; r < 32; r++) begin prog[nprog] = enc(6'h0, 0, 0, r, 5'h0, F_ADDM); nprog++; end
    prog[nprog] = enc(6'h0, 1, 2, 5, 5'h0, F_ADD);   nprog++;  // R3
    prog[nprog] = enc(6'h0, 0, 5, 9, 5'h0, F_ADDM);  nprog++;  // R6 read zero as address
    prog[nprog] = enc(6'h0, 5, 5, 10, 5'h0, F_ADDM); nprog++;  // R3 observe r5
    prog[nprog] = enc(6'h0, 3, 4, 0, 5'h0, F_ADD);   nprog++;  // R6 write r0
    prog[nprog] = enc(6'h0, 0, 0, 11, 5'h0, F_ADDM); nprog++;  // R6 observe r0
    prog[nprog] = enc(6'h23, 1, 2, 3, 5'h0, F_ADD);  nprog++;  // R7 bad opcode
    prog[nprog] = enc(6'h0, 1, 2, 3, 5'h0, 6'h21);   nprog++;  // R7 bad funct
    prog[nprog] = enc(6'h0, 1, 2, 3, 5'h4, F_ADD);   nprog++;  // R7 nonzero shift field
    prog[nprog] = enc(6'h0, 3, 0, 12, 5'h0, F_ADDM); nprog++;  // R7 r3 untouched
    prog[nprog] = enc(6'h0, 10, 9, 13, 5'h0, F_ADD); nprog++;
    prog[nprog] = enc(6'h0, 13, 13, 14, 5'h0, F_ADDM); nprog++; // R3 observe r13
    while (nprog < 200) begin
      kind = int'($urandom % 10);
      rs = int'($urandom % 32); rt = int'($urandom % 32); rd = int'($urandom % 32);
      if (kind < 5)      w = enc(6'h0, rs, rt, rd, 5'h0, F_ADD);
      else if (kind < 9) w = enc(6'h0, rs, rt, rd, 5'h0, F_ADDM);
      else if (kind == 9 && rd[0]) w = enc(6'(1 + $urandom % 63), rs, rt, rd, 5'h0, F_ADD);
      else               w = enc(6'h0, rs, rt, rd, 5'h0, 6'h22);
      prog[nprog] = w; nprog++;
    end
    for (int r = 0; r < 32; r++) rf[r] = '0;

    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      chk(mem_req === 1'b0 && illegal === 1'b0 && bus_err === 1'b0, "R1",
          "outputs during reset", {29'd0, mem_req, illegal, bus_err}, 32'd0);
    end
    rst = 1'b0;

    exp_ill = 0; exp_t = 0; have_t = 1'b0;
    for (int i = 0; i < nprog; i++) begin
      l1 = pick_lat(i);
      serve(32'(4 * i), (i == 0) ? "R1" : "R2", l1, t0);
      if (have_t) chk(t0 == exp_t, "R3/R4/R7", "fetch-to-fetch cycles", 32'(t0), 32'(exp_t));
      chk(ill_seen == exp_ill, "R7", "illegal pulse cycles", 32'(ill_seen), 32'(exp_ill));
      chk(bus_err === 1'b0, "R8", "bus contention flag", 32'(bus_err), 32'd0);
      have_t = 1'b1;
      w  = prog[i];
      rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
      if (w[31:26] == 6'h0 && w[10:6] == 5'h0 && w[5:0] == F_ADD) begin
        v = rf[rs] + rf[rt];
        if (rd != 0) rf[rd] = v;
        exp_t = t0 + l1 + 10;
      end else if (w[31:26] == 6'h0 && w[10:6] == 5'h0 && w[5:0] == F_ADDM) begin
        l2 = pick_lat(i + 7);
        serve(rf[rs], "R4", l2, t1);
        v = mem_word(rf[rs]) + rf[rt];
        if (rd != 0) rf[rd] = v;
        exp_t = t0 + l1 + l2 + 11;
      end else begin
        exp_ill++;
        exp_t = t0 + l1 + 4;
      end
    end
    while (!mem_req) @(negedge clk);
    chk(mem_addr === 32'(4 * nprog), "R2", "fetch after last instruction",
        mem_addr, 32'(4 * nprog));
    chk(cyc == exp_t, "R3/R4/R7", "final fetch-to-fetch cycles", 32'(cyc), 32'(exp_t));
    chk(ill_seen == exp_ill, "R7", "final illegal count", 32'(ill_seen), 32'(exp_ill));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule